// File: doc/BRIEF.md
# Memory Cycle Recycle Timer

This block models the timing chain of a machine whose memory cycle is a ring of named timing pulses. A free-running tick counter, advanced by a fast clock, produces a one-tick strobe at each of a fixed set of evenly spaced slots. A recycle flag decides whether the ring may start over. The flag is cleared early in every cycle and set again near its end, which arms the next cycle.

A diagnostic instruction can stretch the cycle. A one-tick strobe reports that the instruction ran. The block then latches a sticky stretch mode, which holds until the master clear. While the mode is active, the recycle flag is no longer set by the late regular slot. An extra slot placed a fixed number of ticks later sets it instead, so every stretched cycle is longer by that number of ticks.

With the default parameters one tick is 10 ns. There are ten slots, one every 10 ticks, so a normal cycle takes 100 ticks. The clear slot is slot 1 and the set slot is slot 9. A stretched cycle adds 13 ticks: its extra slot sits at tick 103 and the cycle takes 113 ticks.

Top module: `recycle_timer`

## Requirements
- R1: While rst_ni is low (master clear), recycle_o is 1, the stretch mode is cleared and the tick position is 0, so slot_o equals 1 (only bit 0 high) and ext_slot_o is 0.
- R2: slot_o bit k is high for exactly one tick, at tick k*10 of each cycle, for k from 0 to 9. At most one bit of {slot_o, ext_slot_o} is high in any tick.
- R3: recycle_o goes to 0 in the tick after the slot 1 strobe. It stays 0 until its set point.
- R4: In a normal cycle, recycle_o goes to 1 in the tick after the slot 9 strobe. A new cycle starts with slot 0 only while recycle_o is 1, so recycle_o is 1 whenever slot_o bit 0 is high. A normal cycle lasts 100 ticks.
- R5: In a stretched cycle, the slot 9 strobe leaves recycle_o at 0. ext_slot_o pulses for one tick at tick 103, and recycle_o goes to 1 in the following tick. A stretched cycle lasts 113 ticks. ext_slot_o stays 0 in normal cycles.
- R6: A one-tick high on stretch_i latches the stretch mode. The cycle in progress keeps its length, and the mode takes effect from the next slot 0. A strobe in the last tick of a cycle makes the cycle that immediately follows a stretched one.
- R7: The stretch mode stays set through later stretch_i strobes and any number of cycles. Only the master clear removes it, and the next cycle after the clear is normal again (100 ticks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Active-low asynchronous master clear |
| stretch_i | input | 1 | One-tick strobe: stretch-diagnostic instruction executed |
| slot_o | output | NUM_SLOTS | One-hot slot strobes, bit k at tick k*SLOT_TICKS |
| ext_slot_o | output | 1 | Extra slot strobe in stretched cycles |
| recycle_o | output | 1 | Recycle flag; a new cycle may start only while it is 1 |

## Verification
Two functions can fall in the same tick: the latching of a stretch strobe and the wrap of the tick counter into a new cycle. The bench provokes this by driving stretch_i high exactly in tick 99 of a normal cycle. It then expects slot 0 in the very next tick, followed by a full 113-tick stretched cycle. A strobe placed mid-cycle must leave the running cycle at 100 ticks, which separates the two cases.

// File: rtl/rct_pkg.sv
package rct_pkg;
  localparam int unsigned SLOT_TICKS_D    = 10;
  localparam int unsigned NUM_SLOTS_D     = 10;
  localparam int unsigned CLR_SLOT_D      = 1;
  localparam int unsigned SET_SLOT_D      = 9;
  localparam int unsigned STRETCH_TICKS_D = 13;
endpackage

// File: rtl/rct_mode.sv
module rct_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stretch_i,
  input  logic wrap_i,
  output logic act_o
);
  logic mode_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (stretch_i) mode_q <= 1'b1;
      // mode is sampled only at a cycle boundary; same-tick strobe counts
      if (wrap_i) act_q <= mode_q | stretch_i;
    end
  end

  assign act_o = act_q;

  p_mode_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |=> mode_q);
  p_act_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(act_q));
endmodule

// File: rtl/rct_tick_cnt.sv
module rct_tick_cnt #(
  parameter int unsigned CW       = 7,
  parameter int unsigned NORM_LEN = 100,
  parameter int unsigned STR_LEN  = 113
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          rcy_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, last;
  logic          at_last;

  assign last    = act_i ? CW'(STR_LEN - 1) : CW'(NORM_LEN - 1);
  assign at_last = (cnt_q == last);
  assign wrap_o  = at_last && rcy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (!at_last) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_hold_unarmed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_last && !rcy_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rct_slot_dec.sv
module rct_slot_dec #(
  parameter int unsigned CW         = 7,
  parameter int unsigned NUM_SLOTS  = 10,
  parameter int unsigned SLOT_TICKS = 10,
  parameter int unsigned XTICK      = 103
) (
  input  logic [CW-1:0]        cnt_i,
  input  logic                 act_i,
  output logic [NUM_SLOTS-1:0] slot_o,
  output logic                 xslot_o
);
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign slot_o[k] = (cnt_i == CW'(k * SLOT_TICKS));
  end

  assign xslot_o = act_i && (cnt_i == CW'(XTICK));
endmodule

// File: rtl/recycle_timer.sv
module recycle_timer
  import rct_pkg::*;
#(
  parameter int unsigned SLOT_TICKS    = SLOT_TICKS_D,
  parameter int unsigned NUM_SLOTS     = NUM_SLOTS_D,
  parameter int unsigned CLR_SLOT      = CLR_SLOT_D,
  parameter int unsigned SET_SLOT      = SET_SLOT_D,
  parameter int unsigned STRETCH_TICKS = STRETCH_TICKS_D
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stretch_i,
  output logic [NUM_SLOTS-1:0] slot_o,
  output logic                 ext_slot_o,
  output logic                 recycle_o
);
  localparam int unsigned NORM_LEN = NUM_SLOTS * SLOT_TICKS;
  localparam int unsigned STR_LEN  = NORM_LEN + STRETCH_TICKS;
  localparam int unsigned XTICK    = SET_SLOT * SLOT_TICKS + STRETCH_TICKS;
  localparam int unsigned CW       = $clog2(STR_LEN);

  logic          act, wrap, rcy_q, set_pulse;
  logic [CW-1:0] cnt;

  rct_mode u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stretch_i(stretch_i),
    .wrap_i   (wrap),
    .act_o    (act)
  );

  rct_tick_cnt #(.CW(CW), .NORM_LEN(NORM_LEN), .STR_LEN(STR_LEN)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (act),
    .rcy_i (rcy_q),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  rct_slot_dec #(.CW(CW), .NUM_SLOTS(NUM_SLOTS), .SLOT_TICKS(SLOT_TICKS),
                 .XTICK(XTICK)) u_dec (
    .cnt_i  (cnt),
    .act_i  (act),
    .slot_o (slot_o),
    .xslot_o(ext_slot_o)
  );

  assign set_pulse = act ? ext_slot_o : slot_o[SET_SLOT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rcy_q <= 1'b1;
    else if (slot_o[CLR_SLOT])  rcy_q <= 1'b0;
    else if (set_pulse)         rcy_q <= 1'b1;
  end

  assign recycle_o = rcy_q;

  p_one_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({slot_o, ext_slot_o}));
  p_rcy_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o[CLR_SLOT] |=> !recycle_o);
  p_rcy_set_norm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o[SET_SLOT] && !act) |=> recycle_o);
  p_start_armed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o[0] |-> recycle_o);
  p_no_early_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o[SET_SLOT] && act) |=> !recycle_o);
  p_rcy_set_ext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_slot_o |=> recycle_o);
endmodule

// File: tb/recycle_timer_tb.sv
module recycle_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       stretch_i = 1'b0;
  logic [9:0] slot_o;
  logic       ext_slot_o, recycle_o;
  int         n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  recycle_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .stretch_i(stretch_i),
    .slot_o(slot_o), .ext_slot_o(ext_slot_o), .recycle_o(recycle_o)
  );

  typedef logic [13:0] vec_t; // {stretched, offset[6:0], slot[3:0] (15=none), ext, rcy}
  function automatic vec_t mk(input bit m, input int off, input int s,
                              input bit x, input bit r);
    return {m, 7'(off), 4'(s), x, r};
  endfunction

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    mk(0, 0, 0, 0, 1),   mk(0, 10, 1, 0, 1),  mk(0, 11, 15, 0, 0),
    mk(0, 50, 5, 0, 0),  mk(0, 90, 9, 0, 0),  mk(0, 91, 15, 0, 1),
    mk(0, 99, 15, 0, 1), mk(1, 0, 0, 0, 1),   mk(1, 10, 1, 0, 1),
    mk(1, 11, 15, 0, 0), mk(1, 90, 9, 0, 0),  mk(1, 91, 15, 0, 0),
    mk(1, 103, 15, 1, 0), mk(1, 104, 15, 0, 1), mk(1, 112, 15, 0, 1)
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic sync_start();
    for (int i = 0; i < 300 && !slot_o[0]; i++) step(1);
  endtask

  task automatic period(output int p);
    sync_start();
    p = 0;
    do begin step(1); p++; end while (!slot_o[0] && p < 300);
  endtask

  task automatic pulse();
    stretch_i = 1'b1; step(1); stretch_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; step(2);
    check("R1 rcy in clear", int'(recycle_o), 1);
    check("R1 slot in clear", int'(slot_o), 1);
    check("R1 ext in clear", int'(ext_slot_o), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int p;
    @(negedge clk_i);
    do_reset();
    // table walk: R2/R3/R4 normal, then R5 stretched
    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      if (i > 0 && v[13] && !VEC[i-1][13]) pulse();
      sync_start();
      step(int'(v[12:6]));
      check($sformatf("R2 slot @%0d", v[12:6]), int'(slot_o),
            (v[5:2] == 4'd15) ? 0 : (1 << v[5:2]));
      check($sformatf("R5 ext @%0d", v[12:6]), int'(ext_slot_o), int'(v[1]));
      check($sformatf("R3/R4 rcy @%0d", v[12:6]), int'(recycle_o), int'(v[0]));
    end
    // R1 + R4: clear returns to normal period
    do_reset();
    period(p); check("R4 normal period", p, 100);
    // R6: mid-cycle strobe leaves running cycle intact
    do_reset();
    step(50); pulse();
    p = 0;
    do begin step(1); p++; end while (!slot_o[0] && p < 300);
    check("R6 running cycle remainder", p, 49);
    period(p); check("R6 next cycle stretched", p, 113);
    // R7: repeated strobe, mode persists
    step(30); pulse();
    period(p); check("R7 still stretched", p, 113);
    period(p); check("R7 stretched later", p, 113);
    do_reset();
    period(p); check("R7 clear restores normal", p, 100);
    // R6 collision: strobe on last tick of a normal cycle
    do_reset();
    step(99);
    stretch_i = 1'b1; step(1); stretch_i = 1'b0;
    check("R6 wrap after last tick", int'(slot_o[0]), 1);
    period(p); check("R6 same-tick strobe stretches next", p, 113);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule